// File: doc/BRIEF.md
# Security-Banked Configuration Control Register

This block holds one memory-mapped configuration register in two copies: one for the Secure world and one for the Non-secure world. A secure attribute on each bus access picks the copy that the access reads or writes. One bit, the bus-fault-ignore flag, is shared by both worlds. It is stored only in the Non-secure copy, but both worlds can see it and update it. A parameter selects the newer architecture variant. In that variant, the thread-reentry enable bit and the stack-alignment bit always hold one after any write.

The register bus carries a request strobe, an address, a write flag, write data and two attributes: secure and unprivileged. The block answers with read data and an error flag in the cycle after it samples the request. Unprivileged accesses are refused, with one exception: the software interrupt-trigger offset. That offset is permitted when the user-set-pending bit is set in the copy that the access's secure attribute selects. The block decodes that offset for permission only and does not act on it. Two control outputs, stack alignment and thread-reentry enable, feed exception entry and exit logic. They come from the copy that matches the core's current security state.

Top module: `banked_cfg_regs`

## Requirements
- R1: After reset, both copies read 0x200, which is the stack-alignment bit (bit 9) alone. With NEWER_ARCH=1, both copies read 0x201, which adds bit 0.
- R2: A privileged access at offset 0xD14 uses the Non-secure copy when req_secure=0 and the Secure copy when req_secure=1. A write to one copy leaves the other copy unchanged, except for bit 8 as R4 describes.
- R3: Only bits 0, 1, 3, 4, 8 and 9 can be written. All other bits read as zero.
- R4: Bit 8 (bus-fault-ignore) is stored only in the Non-secure copy. A Secure write updates it from wdata[8]. A read from either world returns the Non-secure value of bit 8.
- R5: With NEWER_ARCH=1, every write stores bits 0 and 9 as one, whatever the write data holds.
- R6: An unprivileged access to offset 0xF00 completes with no error and read data zero when bit 1 (user-set-pending) is set in the copy that req_secure selects. Otherwise it returns an error. This holds whatever core_secure is.
- R7: Every other unprivileged access returns rsp_err=1 and read data zero, and it changes no register bit.
- R8: A privileged access to any offset other than 0xD14 returns zero with no error. A write there changes nothing.
- R9: stkalign_o is bit 9 and thrd_reent_o is bit 0 of the copy that core_secure selects (0 selects Non-secure, 1 selects Secure).
- R10: rsp_rdata and rsp_err are valid in the cycle after a request is sampled. They are zero in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, sampled at the rising edge |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_secure | input | 1 | Security attribute of the access; picks the copy |
| req_user | input | 1 | Access is unprivileged |
| rsp_rdata | output | DATA_W | Read data, one cycle after the request |
| rsp_err | output | 1 | Bus error, one cycle after the request |
| core_secure | input | 1 | Current security state of the core |
| stkalign_o | output | 1 | Stack-alignment control from the current-state copy |
| thrd_reent_o | output | 1 | Thread-reentry enable from the current-state copy |

## Verification
The hardest case to reach is the cross-world permission check: an unprivileged trigger access carries the Non-secure attribute while core_secure is high. The permission must then follow the Non-secure copy's user-set-pending bit, not the copy of the core's state. The bench gets there in three steps. It uses privileged writes to give the two copies opposite user-set-pending values, raises core_secure, and then issues unprivileged trigger accesses with each attribute. A second case is a Secure write that changes only the shared bit 8. The bench checks it by reading the Non-secure copy back afterwards.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   localparam int BIT_REENT   = 0;
   localparam int BIT_UPEND   = 1;
   localparam int BIT_UNALGN  = 3;
   localparam int BIT_DIVZ    = 4;
   localparam int BIT_BFIGN   = 8;
   localparam int BIT_STKAL   = 9;
   localparam int MIN_DATA_W  = 10;

   localparam logic [31:0] WR_MASK32 = (32'd1 << BIT_REENT) | (32'd1 << BIT_UPEND) |
                                       (32'd1 << BIT_UNALGN) | (32'd1 << BIT_DIVZ) |
                                       (32'd1 << BIT_BFIGN) | (32'd1 << BIT_STKAL);
   localparam logic [31:0] FORCE32   = (32'd1 << BIT_REENT) | (32'd1 << BIT_STKAL);
   localparam logic [31:0] SHARED32  = (32'd1 << BIT_BFIGN);
endpackage

// File: rtl/bcr_access_gate.sv
module bcr_access_gate #(
   parameter int ADDR_W = 12,
   parameter logic [ADDR_W-1:0] CFG_OFS  = 'hD14,
   parameter logic [ADDR_W-1:0] TRIG_OFS = 'hF00
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              user,
   input  logic              secure,
   input  logic              upend_ns,
   input  logic              upend_s,
   output logic              cfg_wr,
   output logic              cfg_rd,
   output logic              fault
);
   logic hit_cfg, hit_trig, upend_sel, user_ok;

   always_comb begin
      hit_cfg   = (addr == CFG_OFS);
      hit_trig  = (addr == TRIG_OFS);
      upend_sel = secure ? upend_s : upend_ns;
      user_ok   = hit_trig && upend_sel;
      fault     = valid && user && !user_ok;
      cfg_wr    = valid && !user && wr && hit_cfg;
      cfg_rd    = valid && !user && !wr && hit_cfg;
   end
endmodule

// File: rtl/bcr_bank_store.sv
module bcr_bank_store #(
   parameter int DATA_W     = 32,
   parameter bit NEWER_ARCH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wsec,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] copy_ns,
   output logic [DATA_W-1:0] copy_s
);
   localparam logic [DATA_W-1:0] WMASK  = DATA_W'(bcr_pkg::WR_MASK32);
   localparam logic [DATA_W-1:0] FORCE  = DATA_W'(bcr_pkg::FORCE32);
   localparam logic [DATA_W-1:0] SHARED = DATA_W'(bcr_pkg::SHARED32);
   localparam logic [DATA_W-1:0] RST_VAL =
      NEWER_ARCH ? FORCE : (DATA_W'(1) << bcr_pkg::BIT_STKAL);

   logic [DATA_W-1:0] wval;

   generate
      if (NEWER_ARCH) begin : g_forced
         assign wval = (wdata & WMASK) | FORCE;
      end else begin : g_plain
         assign wval = wdata & WMASK;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         copy_ns <= RST_VAL;
         copy_s  <= RST_VAL;
      end else if (we) begin
         if (wsec) begin
            copy_ns <= (copy_ns & ~SHARED) | (wval & SHARED);
            copy_s  <= wval & ~SHARED;
         end else begin
            copy_ns <= wval;
         end
      end
   end
endmodule

// File: rtl/bcr_read_mux.sv
module bcr_read_mux #(
   parameter int DATA_W = 32
) (
   input  logic              sel_s,
   input  logic [DATA_W-1:0] copy_ns,
   input  logic [DATA_W-1:0] copy_s,
   output logic [DATA_W-1:0] view
);
   localparam logic [DATA_W-1:0] SHARED = DATA_W'(bcr_pkg::SHARED32);

   always_comb begin
      view = (sel_s ? copy_s : copy_ns) | (copy_ns & SHARED);
   end
endmodule

// File: rtl/banked_cfg_regs.sv
module banked_cfg_regs #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter bit NEWER_ARCH = 1'b0,
   parameter logic [ADDR_W-1:0] CFG_OFS  = 'hD14,
   parameter logic [ADDR_W-1:0] TRIG_OFS = 'hF00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_secure,
   input  logic              req_user,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   input  logic              core_secure,
   output logic              stkalign_o,
   output logic              thrd_reent_o
);
   generate
      if (DATA_W < bcr_pkg::MIN_DATA_W) begin : g_bad_w
         $error("DATA_W must cover bit 9");
      end
      if (CFG_OFS == TRIG_OFS) begin : g_bad_ofs
         $error("register and trigger offsets must differ");
      end
   endgenerate

   logic [DATA_W-1:0] copy_ns, copy_s, view, ctl_copy;
   logic              cfg_wr, cfg_rd, fault;

   bcr_access_gate #(
      .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .TRIG_OFS(TRIG_OFS)
   ) u_gate (
      .valid    (req_valid),
      .addr     (req_addr),
      .wr       (req_wr),
      .user     (req_user),
      .secure   (req_secure),
      .upend_ns (copy_ns[bcr_pkg::BIT_UPEND]),
      .upend_s  (copy_s[bcr_pkg::BIT_UPEND]),
      .cfg_wr   (cfg_wr),
      .cfg_rd   (cfg_rd),
      .fault    (fault)
   );

   bcr_bank_store #(.DATA_W(DATA_W), .NEWER_ARCH(NEWER_ARCH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_wr),
      .wsec    (req_secure),
      .wdata   (req_wdata),
      .copy_ns (copy_ns),
      .copy_s  (copy_s)
   );

   bcr_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .sel_s   (req_secure),
      .copy_ns (copy_ns),
      .copy_s  (copy_s),
      .view    (view)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_rdata <= cfg_rd ? view : '0;
         rsp_err   <= fault;
      end
   end

   always_comb begin
      ctl_copy     = core_secure ? copy_s : copy_ns;
      stkalign_o   = ctl_copy[bcr_pkg::BIT_STKAL];
      thrd_reent_o = ctl_copy[bcr_pkg::BIT_REENT];
   end
endmodule

// File: rtl/banked_cfg_regs_chk.sv
module banked_cfg_regs_chk #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter bit NEWER_ARCH = 1'b0,
   parameter logic [ADDR_W-1:0] CFG_OFS  = 'hD14,
   parameter logic [ADDR_W-1:0] TRIG_OFS = 'hF00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_wr,
   input logic              req_user,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_err,
   input logic              core_secure,
   input logic              stkalign_o,
   input logic              thrd_reent_o
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(bcr_pkg::WR_MASK32);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (rsp_rdata == '0) && !rsp_err);

   // R7
   user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_user && (req_addr != TRIG_OFS) |=> rsp_err && (rsp_rdata == '0));

   // R7
   user_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_user |=> ($stable(core_secure) ->
                                 ($stable(stkalign_o) && $stable(thrd_reent_o))));

   // R6
   trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_addr == TRIG_OFS) |=> (rsp_rdata == '0));

   // R8
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_user && (req_addr != CFG_OFS) |=> (rsp_rdata == '0) && !rsp_err);

   // R3
   unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_user && !req_wr && (req_addr == CFG_OFS)
      |=> ((rsp_rdata & ~WMASK) == '0) && !rsp_err);

   generate
      if (NEWER_ARCH) begin : g_v8
         // R5
         forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && !req_user && !req_wr && (req_addr == CFG_OFS)
            |=> rsp_rdata[bcr_pkg::BIT_REENT] && rsp_rdata[bcr_pkg::BIT_STKAL]);
         // R5
         forced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |-> stkalign_o && thrd_reent_o);
      end
   endgenerate
endmodule

bind banked_cfg_regs banked_cfg_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NEWER_ARCH(NEWER_ARCH),
   .CFG_OFS(CFG_OFS), .TRIG_OFS(TRIG_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_wr(req_wr), .req_user(req_user), .rsp_rdata(rsp_rdata),
   .rsp_err(rsp_err), .core_secure(core_secure), .stkalign_o(stkalign_o),
   .thrd_reent_o(thrd_reent_o)
);

// File: tb/tb_banked_cfg_regs.sv
`timescale 1ns/1ps
module tb_banked_cfg_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic        req_wr = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_secure = 1'b0;
   logic        req_user = 1'b0;
   logic        core_secure = 1'b0;
   logic [31:0] rdata, rdata8;
   logic        err, err8;
   logic        stk, thr, stk8, thr8;

   int nvec = 0;
   int nbad = 0;

   localparam logic [11:0] CFG  = 12'hD14;
   localparam logic [11:0] TRIG = 12'hF00;
   localparam logic [11:0] HOLE = 12'h010;

   always #2 clk = ~clk;

   banked_cfg_regs dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wr(req_wr), .req_wdata(req_wdata), .req_secure(req_secure),
      .req_user(req_user), .rsp_rdata(rdata), .rsp_err(err),
      .core_secure(core_secure), .stkalign_o(stk), .thrd_reent_o(thr)
   );

   banked_cfg_regs #(.NEWER_ARCH(1'b1)) dut_v8 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wr(req_wr), .req_wdata(req_wdata), .req_secure(req_secure),
      .req_user(req_user), .rsp_rdata(rdata8), .rsp_err(err8),
      .core_secure(core_secure), .stkalign_o(stk8), .thrd_reent_o(thr8)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // one bus access; response captured at the negedge after the sampling edge
   task automatic xfer(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic sec, input logic usr);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_wr = w; req_wdata = d;
      req_secure = sec; req_user = usr;
      @(negedge clk);
      req_valid = 1'b0; req_wr = 1'b0; req_user = 1'b0; req_wdata = '0;
   endtask

   task automatic rd_cfg(input logic sec, input logic [31:0] exp, input string tag);
      xfer(CFG, 1'b0, 32'h0, sec, 1'b0);
      chk({tag, " data"}, rdata, exp);
      chk({tag, " err"}, {31'd0, err}, 32'd0);
   endtask

   task automatic t_reset();
      rd_cfg(1'b0, 32'h200, "R1 ns reset");
      chk("R1 v8 ns reset", rdata8, 32'h201);
      rd_cfg(1'b1, 32'h200, "R1 s reset");
      chk("R1 v8 s reset", rdata8, 32'h201);
      chk("R1 stk", {31'd0, stk}, 32'd1);
      chk("R1 thr", {31'd0, thr}, 32'd0);
   endtask

   task automatic t_banking();
      xfer(CFG, 1'b1, 32'h013, 1'b0, 1'b0);
      chk("R2 write err", {31'd0, err}, 32'd0);
      rd_cfg(1'b0, 32'h013, "R2 ns after ns write");
      rd_cfg(1'b1, 32'h200, "R2 s untouched");
      xfer(CFG, 1'b1, 32'h219, 1'b1, 1'b0);
      rd_cfg(1'b1, 32'h219, "R2 s after s write");
      rd_cfg(1'b0, 32'h013, "R2 ns untouched");
   endtask

   task automatic t_mask();
      xfer(CFG, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd_cfg(1'b0, 32'h31B, "R3 ns all ones");
      rd_cfg(1'b1, 32'h319, "R3 R4 s sees shared bit");
   endtask

   task automatic t_shared();
      xfer(CFG, 1'b1, 32'h000, 1'b1, 1'b0);
      rd_cfg(1'b0, 32'h21B, "R4 s write clears ns bit8");
      rd_cfg(1'b1, 32'h000, "R4 s copy zero");
      xfer(CFG, 1'b1, 32'h100, 1'b1, 1'b0);
      rd_cfg(1'b0, 32'h31B, "R4 s write sets ns bit8");
      rd_cfg(1'b1, 32'h100, "R4 s reads shared bit");
   endtask

   task automatic t_ctrl();
      @(negedge clk); core_secure = 1'b0; #1;
      chk("R9 ns stk", {31'd0, stk}, 32'd1);
      chk("R9 ns thr", {31'd0, thr}, 32'd1);
      core_secure = 1'b1; #1;
      chk("R9 s stk", {31'd0, stk}, 32'd0);
      chk("R9 s thr", {31'd0, thr}, 32'd0);
   endtask

   task automatic t_trigger();
      xfer(CFG, 1'b1, 32'h002, 1'b0, 1'b0);
      xfer(CFG, 1'b1, 32'h000, 1'b1, 1'b0);
      core_secure = 1'b1;
      xfer(TRIG, 1'b1, 32'h5, 1'b0, 1'b1);
      chk("R6 ns attr allowed under secure core", {31'd0, err}, 32'd0);
      chk("R6 data zero", rdata, 32'd0);
      xfer(TRIG, 1'b0, 32'h0, 1'b1, 1'b1);
      chk("R6 s attr refused", {31'd0, err}, 32'd1);
      xfer(CFG, 1'b1, 32'h000, 1'b0, 1'b0);
      xfer(CFG, 1'b1, 32'h002, 1'b1, 1'b0);
      xfer(TRIG, 1'b0, 32'h0, 1'b1, 1'b1);
      chk("R6 s attr allowed", {31'd0, err}, 32'd0);
      core_secure = 1'b0;
      xfer(TRIG, 1'b0, 32'h0, 1'b0, 1'b1);
      chk("R6 ns attr refused", {31'd0, err}, 32'd1);
   endtask

   task automatic t_user();
      xfer(CFG, 1'b1, 32'h3FF, 1'b0, 1'b1);
      chk("R7 user write err", {31'd0, err}, 32'd1);
      xfer(CFG, 1'b0, 32'h0, 1'b1, 1'b1);
      chk("R7 user read err", {31'd0, err}, 32'd1);
      chk("R7 user read data", rdata, 32'd0);
      rd_cfg(1'b0, 32'h000, "R7 ns unchanged");
      rd_cfg(1'b1, 32'h002, "R7 s unchanged");
   endtask

   task automatic t_unmapped();
      xfer(HOLE, 1'b1, 32'h3FF, 1'b0, 1'b0);
      chk("R8 write no err", {31'd0, err}, 32'd0);
      xfer(HOLE, 1'b0, 32'h0, 1'b0, 1'b0);
      chk("R8 read zero", rdata, 32'd0);
      chk("R8 read no err", {31'd0, err}, 32'd0);
      xfer(TRIG, 1'b0, 32'h0, 1'b1, 1'b0);
      chk("R8 priv trig read zero", rdata, 32'd0);
      rd_cfg(1'b0, 32'h000, "R8 ns unchanged");
   endtask

   task automatic t_timing();
      xfer(CFG, 1'b0, 32'h0, 1'b1, 1'b0);
      chk("R10 data next cycle", rdata, 32'h002);
      @(negedge clk);
      chk("R10 idle data", rdata, 32'd0);
      chk("R10 idle err", {31'd0, err}, 32'd0);
   endtask

   task automatic t_newer();
      xfer(CFG, 1'b1, 32'h000, 1'b0, 1'b0);
      chk("R5 v8 ns forced", rdata8, 32'h0);
      xfer(CFG, 1'b0, 32'h0, 1'b0, 1'b0);
      chk("R5 v8 ns read", rdata8, 32'h201);
      xfer(CFG, 1'b1, 32'h100, 1'b1, 1'b0);
      xfer(CFG, 1'b0, 32'h0, 1'b1, 1'b0);
      chk("R5 v8 s read", rdata8, 32'h301);
      xfer(CFG, 1'b0, 32'h0, 1'b0, 1'b0);
      chk("R5 v8 ns bit8", rdata8, 32'h301);
      #1;
      chk("R5 v8 thr out", {31'd0, thr8}, 32'd1);
      chk("R5 v8 stk out", {31'd0, stk8}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_banking();
      t_mask();
      t_shared();
      t_ctrl();
      t_trigger();
      t_user();
      t_unmapped();
      t_timing();
      t_newer();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule